// File: doc/BRIEF.md
# Emulated Internal Tri-State Bus

This block stands in for a shared on-chip bus that would otherwise be built from tri-state buffers. Several sources each present a data word and an output-enable bit. The block merges them into one resolved word using only AND-OR selection logic, and there are no high-impedance drivers anywhere inside it.

The bus output is never left undefined. When exactly one source is enabled, that source's word passes through unchanged. When two or more sources are enabled together, the clash is settled by forcing every bus bit to 0. When no source is enabled, every bus bit is forced to 1. Two flags report the clash and idle conditions.

The whole path is combinational, so the output follows the inputs within the same cycle. The number of sources and the word width are parameters.

Top module: `emu_tristate_bus`

## Requirements
- R1: When exactly one bit of `drv_oe` is 1, `bus_out` equals that driver's data word bit for bit.
- R2: When two or more bits of `drv_oe` are 1, every bit of `bus_out` is 0.
- R3: When no bit of `drv_oe` is 1, every bit of `bus_out` is 1.
- R4: `clash` is 1 exactly when more than one bit of `drv_oe` is 1.
- R5: `idle` is 1 exactly when no bit of `drv_oe` is 1.
- R6: The outputs are purely combinational. A change on `drv_oe` or `drv_data` reaches `bus_out`, `clash` and `idle` without waiting for any clock edge.
- R7: The data words of drivers whose enable is 0 have no effect on any output.
- R8: Driver k uses enable bit `drv_oe[k]` and data slice `drv_data[k*DATA_W +: DATA_W]`. The parameter `N_DRV` is at least 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| drv_data | input | N_DRV*DATA_W | Flattened data words; driver k in slice k*DATA_W +: DATA_W |
| drv_oe | input | N_DRV | Output-enable per driver, bit k for driver k |
| bus_out | output | DATA_W | Resolved bus word |
| clash | output | 1 | High when more than one enable is active |
| idle | output | 1 | High when no enable is active |

## Verification
The bench walks through every one of the 2^N_DRV enable patterns, three times each with fresh random data words. This separates the idle case (all ones), the single-driver cases (each pattern picks a different slice, which exposes index mapping errors) and the clash cases (all zeros), and it confirms the flags for every pattern. A directed step holds one enable fixed while the words of the disabled drivers are rewritten, which shows that those words do not leak onto the bus. A further step checks the output shortly after an input change with no clock edge in between, which shows that the path is combinational.

// File: rtl/emu_bus_pkg.sv
package emu_bus_pkg;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_SOLE  = 2'd1,
        BUS_CLASH = 2'd2
    } bus_mode_e;

    function automatic bus_mode_e classify(input logic [31:0] active_cnt);
        if (active_cnt == 32'd0)      return BUS_IDLE;
        else if (active_cnt == 32'd1) return BUS_SOLE;
        else                          return BUS_CLASH;
    endfunction

endpackage

// File: rtl/tsb_oe_decode.sv
module tsb_oe_decode
    import emu_bus_pkg::*;
#(
    parameter int N_DRV = 4
) (
    input  logic [N_DRV-1:0] oe,
    output bus_mode_e        mode,
    output logic [N_DRV-1:0] grant
);
    localparam int CW = $clog2(N_DRV + 1);

    logic [CW-1:0] active_cnt;

    always_comb begin
        active_cnt = '0;
        for (int i = 0; i < N_DRV; i++) begin
            active_cnt = active_cnt + CW'(oe[i]);
        end
    end

    always_comb begin
        mode  = classify(32'(active_cnt));
        grant = (mode == BUS_SOLE) ? oe : '0;
    end

    always_comb begin
        AST_GRANT_ONEHOT: assert ($onehot0(grant)); // R1
    end

endmodule

// File: rtl/tsb_andor_mux.sv
module tsb_andor_mux #(
    parameter int N_DRV  = 4,
    parameter int DATA_W = 8
) (
    input  logic [N_DRV-1:0]        grant,
    input  logic [N_DRV*DATA_W-1:0] data,
    output logic [DATA_W-1:0]       picked
);
    logic [DATA_W-1:0] masked [N_DRV];

    for (genvar g = 0; g < N_DRV; g++) begin : g_mask
        assign masked[g] = data[g*DATA_W +: DATA_W] & {DATA_W{grant[g]}};
    end

    always_comb begin
        picked = '0;
        for (int i = 0; i < N_DRV; i++) begin
            picked = picked | masked[i];
        end
    end

endmodule

// File: rtl/tsb_resolve.sv
module tsb_resolve
    import emu_bus_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  bus_mode_e         mode,
    input  logic [DATA_W-1:0] picked,
    output logic [DATA_W-1:0] bus,
    output logic              clash,
    output logic              idle
);
    always_comb begin
        clash = 1'b0;
        idle  = 1'b0;
        unique case (mode)
            BUS_IDLE: begin
                bus  = '1;
                idle = 1'b1;
            end
            BUS_SOLE: bus = picked;
            default: begin
                bus   = '0;
                clash = 1'b1;
            end
        endcase
    end

    always_comb begin
        AST_CLASH_LOW: assert (!clash || bus == '0); // R2
        AST_IDLE_HIGH: assert (!idle || bus == '1); // R3
    end

endmodule

// File: rtl/emu_tristate_bus.sv
module emu_tristate_bus
    import emu_bus_pkg::*;
#(
    parameter int N_DRV  = 4,
    parameter int DATA_W = 8
) (
    input  logic [N_DRV*DATA_W-1:0] drv_data,
    input  logic [N_DRV-1:0]        drv_oe,
    output logic [DATA_W-1:0]       bus_out,
    output logic                    clash,
    output logic                    idle
);
    bus_mode_e         mode;
    logic [N_DRV-1:0]  grant;
    logic [DATA_W-1:0] picked;

    initial begin
        AST_MIN_DRIVERS: assert (N_DRV >= 2); // R8
    end

    tsb_oe_decode #(.N_DRV(N_DRV)) u_decode (
        .oe    (drv_oe),
        .mode  (mode),
        .grant (grant)
    );

    tsb_andor_mux #(.N_DRV(N_DRV), .DATA_W(DATA_W)) u_mux (
        .grant  (grant),
        .data   (drv_data),
        .picked (picked)
    );

    tsb_resolve #(.DATA_W(DATA_W)) u_resolve (
        .mode   (mode),
        .picked (picked),
        .bus    (bus_out),
        .clash  (clash),
        .idle   (idle)
    );

    always_comb begin
        AST_SOLE_PASS:   assert (mode != BUS_SOLE || bus_out == picked); // R1
        AST_CLASH_COUNT: assert (clash == ($countones(drv_oe) > 1)); // R4
        AST_IDLE_COUNT:  assert (idle == (drv_oe == '0)); // R5
        AST_FLAGS_EXCL:  assert (!(clash && idle)); // R4
    end

endmodule

// File: tb/emu_tristate_bus_tb.sv
module emu_tristate_bus_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N_DRV      = 4;
    localparam int DATA_W     = 8;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        logic [DATA_W-1:0] exp_bus;
        logic              exp_clash;
        logic              exp_idle;
        string             req;
    } exp_t;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic [N_DRV*DATA_W-1:0] drv_data = '0;
    logic [N_DRV-1:0]        drv_oe = '0;
    logic [DATA_W-1:0]       bus_out;
    logic                    clash;
    logic                    idle;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    emu_tristate_bus #(.N_DRV(N_DRV), .DATA_W(DATA_W)) u_dut (
        .drv_data (drv_data),
        .drv_oe   (drv_oe),
        .bus_out  (bus_out),
        .clash    (clash),
        .idle     (idle)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic exp_t model(input logic [N_DRV*DATA_W-1:0] d,
                                   input logic [N_DRV-1:0] oe, input string req);
        exp_t e;
        int   cnt = 0;
        int   idx = 0;
        for (int i = 0; i < N_DRV; i++) begin
            if (oe[i]) begin
                cnt++;
                idx = i;
            end
        end
        e.req       = req;
        e.exp_clash = (cnt > 1);
        e.exp_idle  = (cnt == 0);
        if (cnt == 0)      e.exp_bus = '1;
        else if (cnt == 1) e.exp_bus = d[idx*DATA_W +: DATA_W];
        else               e.exp_bus = '0;
        return e;
    endfunction

    task automatic compare(input exp_t e);
        checks++;
        if (bus_out !== e.exp_bus || clash !== e.exp_clash || idle !== e.exp_idle) begin
            errors++;
            $display("FAIL %s: bus=%h clash=%b idle=%b expected bus=%h clash=%b idle=%b",
                     e.req, bus_out, clash, idle, e.exp_bus, e.exp_clash, e.exp_idle);
        end
    endtask

    task automatic drive(input logic [N_DRV*DATA_W-1:0] d, input logic [N_DRV-1:0] oe,
                         input string req);
        @(negedge clk);
        drv_data = d;
        drv_oe   = oe;
        sb_q.push_back(model(d, oe, req));
    endtask

    function automatic logic [N_DRV*DATA_W-1:0] rand_data();
        logic [N_DRV*DATA_W-1:0] v;
        for (int i = 0; i < N_DRV; i++) v[i*DATA_W +: DATA_W] = DATA_W'($urandom);
        return v;
    endfunction

    // Monitor: inputs change on the falling edge, outputs are compared on the rising edge.
    initial begin
        forever begin
            @(posedge clk);
            if (!rst && sb_q.size() > 0) compare(sb_q.pop_front());
        end
    end

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > WATCHDOG) begin
                errors++;
                checks++;
                $display("FAIL watchdog: cycles=%0d expected below %0d", cyc, WATCHDOG);
                $display("  Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        logic [N_DRV*DATA_W-1:0] d;
        string tag;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // Initial state with no enable: R3 and R5
        compare(model(drv_data, drv_oe, "R3 R5 initial"));

        // Every enable pattern with random data: R1 R2 R3 R4 R5 R8
        for (int r = 0; r < 3; r++) begin
            for (int p = 0; p < (1 << N_DRV); p++) begin
                case ($countones(p[N_DRV-1:0]))
                    0:       tag = "R3 R5";
                    1:       tag = "R1 R8";
                    default: tag = "R2 R4";
                endcase
                drive(rand_data(), N_DRV'(p), tag);
            end
        end

        // Each driver alone with a distinctive word: R8
        for (int k = 0; k < N_DRV; k++) begin
            d = '0;
            for (int i = 0; i < N_DRV; i++) d[i*DATA_W +: DATA_W] = DATA_W'(8'h11 * (i + 1));
            drive(d, N_DRV'(1) << k, "R8 mapping");
        end

        // Disabled drivers' words have no effect: R7
        d = '1;
        d[DATA_W-1:0] = DATA_W'(8'hA5);
        drive(d, N_DRV'(1), "R7 baseline");
        d[N_DRV*DATA_W-1:DATA_W] = '0;
        drive(d, N_DRV'(1), "R7 others zero");
        d[N_DRV*DATA_W-1:DATA_W] = rand_data() >> DATA_W;
        drive(d, N_DRV'(1), "R7 others random");

        // Let the scoreboard drain
        while (sb_q.size() > 0) @(posedge clk);

        // Combinational update, checked with no clock edge in between: R6
        @(negedge clk);
        drv_data = rand_data();
        drv_oe   = N_DRV'(4);
        #1 compare(model(drv_data, drv_oe, "R6 single"));
        drv_oe   = N_DRV'(3);
        #1 compare(model(drv_data, drv_oe, "R6 clash"));
        drv_oe   = '0;
        #1 compare(model(drv_data, drv_oe, "R6 idle"));

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule